// File: doc/BRIEF.md
# Banked Lane Scratchpad with Conflict Replay

This block is an on-chip scratchpad shared by a group of parallel request lanes. A request group carries, for every lane, an enable bit, a read/write flag, a word address and write data. The storage is split into banks that interleave on word addresses. Lanes whose addresses fall into different banks are all served in the same cycle. Lanes that hit different words of one bank are replayed over extra cycles. The bank serves one distinct address per cycle.

All lanes that name the same word in a group are served together in one bank cycle. A shared read is a single broadcast. Several writes to one word collapse into one write. The group handshake is plain valid/ready: a group is taken only while the block is idle. A one-cycle done pulse marks the cycle in which every lane's read data is valid. A cycle-count output reports how many bank cycles the last group used.

Top module: `lane_bank_scratch`

## Requirements
- R1: The bank of a word address is its four low bits (address modulo 16, with 16 banks). The remaining upper bits select the row inside that bank.
- R2: A group whose enabled lanes all use distinct banks, such as unit stride or any permutation of banks, is served in one cycle. Done is high in the first cycle after the accepting clock edge.
- R3: A group takes as many cycles as the largest count of distinct addresses that fall into any one bank. A stride of 2 takes 2 cycles and a stride of 8 takes 8. Done follows the accepting edge by exactly that many cycles.
- R4: Lanes that read the same word share one bank cycle and add no replay cycle.
- R5: A read returns the word stored before the group. This holds even when another lane of the same group writes that word. Lanes that write return zero on their read data.
- R6: When several lanes of one group write the same word, the data of the highest-numbered of those lanes is what remains stored.
- R7: in_ready is low from the accepting edge until done is high. in_valid presented while in_ready is low has no effect on the stored words or on the results.
- R8: done is a single-cycle pulse. last_cycles takes the group's cycle count in the same cycle and holds it until the next group finishes.
- R9: A disabled lane takes no part in conflict counting, writes nothing, and returns zero read data.
- R10: A group with no lane enabled completes one cycle after acceptance and reports a count of 1.
- R11: After reset, in_ready is 1, done is 0, last_cycles is 0 and every lane's read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request group is presented |
| in_ready | output | 1 | Block is idle and takes a group |
| lane_en | input | LANES | Per-lane request enable |
| lane_we | input | LANES | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | LANES*AW | Per-lane word address, lane 0 in the low bits |
| lane_wdata | input | LANES*DW | Per-lane write data, lane 0 in the low bits |
| rd_data | output | LANES*DW | Per-lane read data, valid when done is high |
| done | output | 1 | One-cycle pulse at group completion |
| last_cycles | output | $clog2(LANES+1) | Bank cycles used by the last finished group |

## Verification
A leader chosen wrongly, or a pending mask cleared too early or too late, shows first on the done timing. Done then arrives one or more cycles early or late against the per-bank distinct-address count, and last_cycles disagrees in that same cycle. A wrong bank or row decode, or a wrong write merge, shows as wrong read data. That error appears on the group that reads the word back, so the bench reads every written word in a later group. A broken handshake gate changes the stored words, and the next read of address 0 exposes it.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
   typedef enum logic {
      LBS_IDLE = 1'b0,
      LBS_BUSY = 1'b1
   } lbs_state_e;
endpackage

// File: rtl/lbs_bank_pick.sv
// Per-bank arbitration: the lowest pending lane that maps to this bank
// leads; every pending lane on the same word joins it.
module lbs_bank_pick #(
   parameter int LANES   = 16,
   parameter int AW      = 8,
   parameter int DW      = 32,
   parameter int BSEL    = 4,
   parameter int BANK_ID = 0
) (
   input  logic [LANES-1:0]    pending,
   input  logic [LANES*AW-1:0] addr_flat,
   input  logic [LANES-1:0]    we,
   input  logic [LANES*DW-1:0] wdata_flat,
   output logic [LANES-1:0]    serve,
   output logic                wr_en,
   output logic [AW-BSEL-1:0]  row,
   output logic [DW-1:0]       wr_word
);
   logic          found;
   logic [AW-1:0] lead;

   always_comb begin
      found = 1'b0;
      lead  = '0;
      for (int l = 0; l < LANES; l++) begin
         if (!found && pending[l] &&
             addr_flat[l*AW +: BSEL] == BSEL'(BANK_ID)) begin
            found = 1'b1;
            lead  = addr_flat[l*AW +: AW];
         end
      end
      serve   = '0;
      wr_en   = 1'b0;
      wr_word = '0;
      for (int l = 0; l < LANES; l++) begin
         if (found && pending[l] && addr_flat[l*AW +: AW] == lead) begin
            serve[l] = 1'b1;
            if (we[l]) begin
               wr_en   = 1'b1;
               wr_word = wdata_flat[l*DW +: DW];   // later lane overrides
            end
         end
      end
      row = lead[AW-1:BSEL];
   end
endmodule

// File: rtl/lbs_bank_store.sv
// One bank: asynchronous read of the old word, write at the clock edge.
module lbs_bank_store #(
   parameter int DW   = 32,
   parameter int ROWW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [ROWW-1:0] row,
   input  logic [DW-1:0]   wr_word,
   output logic [DW-1:0]   rd_word
);
   localparam int DEPTH = 1 << ROWW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[row] <= wr_word;
   end

   assign rd_word = mem[row];

   // R6: the merged write word is what the row holds afterwards
   p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(row)] == $past(wr_word));
endmodule

// File: rtl/lane_bank_scratch.sv
module lane_bank_scratch
   import lbs_pkg::*;
#(
   parameter int LANES = 16,
   parameter int BANKS = 16,
   parameter int AW    = 8,
   parameter int DW    = 32,
   localparam int BSEL = $clog2(BANKS),
   localparam int ROWW = AW - BSEL,
   localparam int CNTW = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [LANES-1:0]    lane_en,
   input  logic [LANES-1:0]    lane_we,
   input  logic [LANES*AW-1:0] lane_addr,
   input  logic [LANES*DW-1:0] lane_wdata,
   output logic [LANES*DW-1:0] rd_data,
   output logic                done,
   output logic [CNTW-1:0]     last_cycles
);
   // elaboration-time parameter checks
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (AW <= BSEL) begin : g_bad_aw
      $error("AW must exceed the bank select width");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   lbs_state_e          state;
   logic [LANES-1:0]    en_q, we_q, pending;
   logic [LANES*AW-1:0] addr_q;
   logic [LANES*DW-1:0] wdata_q;
   logic [DW-1:0]       rd_q [LANES];
   logic [CNTW-1:0]     cnt;

   logic [LANES-1:0]    serve_mat [BANKS];
   logic [DW-1:0]       bank_rd   [BANKS];
   logic [LANES-1:0]    served, remain;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic            wr_en;
      logic [ROWW-1:0] row;
      logic [DW-1:0]   wr_word;

      lbs_bank_pick #(
         .LANES(LANES), .AW(AW), .DW(DW), .BSEL(BSEL), .BANK_ID(b)
      ) i_pick (
         .pending   (pending),
         .addr_flat (addr_q),
         .we        (we_q),
         .wdata_flat(wdata_q),
         .serve     (serve_mat[b]),
         .wr_en     (wr_en),
         .row       (row),
         .wr_word   (wr_word)
      );

      lbs_bank_store #(.DW(DW), .ROWW(ROWW)) i_store (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_en && state == LBS_BUSY),
         .row    (row),
         .wr_word(wr_word),
         .rd_word(bank_rd[b])
      );
   end

   always_comb begin
      served = '0;
      for (int b = 0; b < BANKS; b++) served |= serve_mat[b];
      remain = pending & ~served;
   end

   assign in_ready = (state == LBS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= LBS_IDLE;
         en_q        <= '0;
         we_q        <= '0;
         pending     <= '0;
         addr_q      <= '0;
         wdata_q     <= '0;
         cnt         <= '0;
         done        <= 1'b0;
         last_cycles <= '0;
         for (int l = 0; l < LANES; l++) rd_q[l] <= '0;
      end else begin
         done <= 1'b0;
         if (state == LBS_IDLE) begin
            if (in_valid) begin
               state   <= LBS_BUSY;
               en_q    <= lane_en;
               we_q    <= lane_we;
               pending <= lane_en;
               addr_q  <= lane_addr;
               wdata_q <= lane_wdata;
               cnt     <= '0;
               for (int l = 0; l < LANES; l++) rd_q[l] <= '0;
            end
         end else begin
            pending <= remain;
            cnt     <= cnt + 1'b1;
            for (int l = 0; l < LANES; l++) begin
               if (served[l] && !we_q[l])
                  rd_q[l] <= bank_rd[addr_q[l*AW +: BSEL]];
            end
            if (remain == '0) begin
               state       <= LBS_IDLE;
               done        <= 1'b1;
               last_cycles <= cnt + 1'b1;
            end
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane_out
      assign rd_data[l*DW +: DW] = rd_q[l];

      // R9: a lane left out of the group reports zero at completion
      p_idle_lane_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         done && !en_q[l] |-> rd_q[l] == '0);
   end

   // R8: completion is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: every busy cycle retires at least one pending lane
   p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LBS_BUSY && pending != '0) |=>
         $countones(pending) < $past($countones(pending)));

   // R3: a group never needs more cycles than there are lanes
   p_cycles_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (last_cycles >= 1 && last_cycles <= CNTW'(LANES)));

   // R7: the block is idle again when it signals completion
   p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> in_ready);
endmodule

// File: tb/test_lane_bank_scratch.sv
module test_lane_bank_scratch;
   localparam int LANES = 16;
   localparam int BANKS = 16;
   localparam int AW    = 8;
   localparam int DW    = 32;
   localparam int CNTW  = $clog2(LANES + 1);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic                in_ready;
   logic [LANES-1:0]    lane_en = '0;
   logic [LANES-1:0]    lane_we = '0;
   logic [LANES*AW-1:0] lane_addr = '0;
   logic [LANES*DW-1:0] lane_wdata = '0;
   logic [LANES*DW-1:0] rd_data;
   logic                done;
   logic [CNTW-1:0]     last_cycles;

   lane_bank_scratch #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW))
   i_lane_bank_scratch (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .lane_en(lane_en), .lane_we(lane_we), .lane_addr(lane_addr),
      .lane_wdata(lane_wdata), .rd_data(rd_data), .done(done),
      .last_cycles(last_cycles)
   );

   always #10 clk = ~clk;   // 50 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [DW-1:0] rd [LANES];
      int            cycles;
      int            done_at;
      string         tag;
   } exp_t;
   exp_t exp_q [$];

   logic [DW-1:0] model [1 << AW];
   logic [LANES-1:0] g_en, g_we;
   logic [AW-1:0]    g_a [LANES];
   logic [DW-1:0]    g_d [LANES];

   // monitor: pop one expected item per completion
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R8: unexpected done at cycle %0d (expected none)", cyc);
         end else begin
            exp_t e;
            int   bad_l;
            e = exp_q.pop_front();
            bad_l = -1;
            for (int l = 0; l < LANES; l++)
               if (bad_l < 0 && rd_data[l*DW +: DW] !== e.rd[l]) bad_l = l;
            n_chk++;
            if (bad_l >= 0) begin
               n_bad++;
               $display("FAIL %s: lane %0d data actual %h expected %h", e.tag,
                        bad_l, rd_data[bad_l*DW +: DW], e.rd[bad_l]);
            end
            n_chk++;
            if (int'(last_cycles) != e.cycles) begin
               n_bad++;
               $display("FAIL %s R8: last_cycles actual %0d expected %0d",
                        e.tag, last_cycles, e.cycles);
            end
            n_chk++;
            if (cyc != e.done_at) begin
               n_bad++;
               $display("FAIL %s R3: done cycle actual %0d expected %0d",
                        e.tag, cyc, e.done_at);
            end
         end
      end
   end

   // driver: present g_* as one group, push expectation, wait for completion
   task automatic run_group(input string tag, input int hold);
      exp_t e;
      int   worst;
      while (!in_ready) @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
         lane_addr[l*AW +: AW]  = g_a[l];
         lane_wdata[l*DW +: DW] = g_d[l];
         e.rd[l] = (g_en[l] && !g_we[l]) ? model[g_a[l]] : '0;
      end
      lane_en = g_en; lane_we = g_we; in_valid = 1'b1;
      worst = 1;
      for (int b = 0; b < BANKS; b++) begin
         int cnt = 0;
         for (int l = 0; l < LANES; l++) begin
            bit seen = 0;
            if (g_en[l] && int'(g_a[l]) % BANKS == b) begin
               for (int k = 0; k < l; k++)
                  if (g_en[k] && g_a[k] == g_a[l]) seen = 1;
               if (!seen) cnt++;
            end
         end
         if (cnt > worst) worst = cnt;
      end
      for (int l = 0; l < LANES; l++)
         if (g_en[l] && g_we[l]) model[g_a[l]] = g_d[l];
      e.cycles  = worst;
      e.done_at = cyc + 1 + worst;
      e.tag     = tag;
      exp_q.push_back(e);
      @(negedge clk);
      if (hold > 0) begin
         // R7: keep valid high with a hostile group while busy
         lane_en = '1; lane_we = '1; lane_addr = '0; lane_wdata = '1;
         repeat (hold) @(negedge clk);
      end
      in_valid = 1'b0; lane_en = '0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung (actual running, expected finished)");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      n_chk++;
      if (!(in_ready === 1'b1 && done === 1'b0 && last_cycles === '0 && rd_data === '0)) begin
         n_bad++;
         $display("FAIL R11: ready/done/cycles/data actual %b/%b/%0d/%h expected 1/0/0/0",
                  in_ready, done, last_cycles, rd_data[DW-1:0]);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2: fill rows with unit-stride writes
      for (int g = 0; g < 9; g++) begin
         g_en = '1; g_we = '1;
         for (int l = 0; l < LANES; l++) begin
            g_a[l] = AW'(g * 16 + l);
            g_d[l] = 32'hA500_0000 + 32'(g * 16 + l) * 3 + 7;
         end
         run_group("R2 fill", 0);
      end
      // R2: unit-stride read
      g_en = '1; g_we = '0;
      for (int l = 0; l < LANES; l++) g_a[l] = AW'(l);
      run_group("R2 unit", 0);
      // R1 R2: permutation of banks
      for (int l = 0; l < LANES; l++) g_a[l] = AW'(((l * 5 + 3) % 16) + 32);
      run_group("R1 perm", 0);
      // R3: stride 2
      for (int l = 0; l < LANES; l++) g_a[l] = AW'(l * 2);
      run_group("R3 stride2", 0);
      // R3 R7: stride 8 with valid held high while busy
      for (int l = 0; l < LANES; l++) g_a[l] = AW'(l * 8);
      run_group("R3 R7 stride8", 3);
      // R4: all lanes read one word
      for (int l = 0; l < LANES; l++) g_a[l] = AW'(5);
      run_group("R4 bcast", 0);
      // R4 R3: two words in bank 8
      for (int l = 0; l < LANES; l++) g_a[l] = (l % 2 == 0) ? AW'(40) : AW'(56);
      run_group("R4 two-word", 0);
      // R6: all lanes write one word
      g_we = '1;
      for (int l = 0; l < LANES; l++) begin
         g_a[l] = AW'(77); g_d[l] = 32'h6000_0000 + 32'(l);
      end
      run_group("R6 merge", 0);
      // R5: read and write of one word in one group
      g_en = '0; g_we = '0;
      g_en[0] = 1; g_en[1] = 1; g_en[2] = 1; g_we[1] = 1;
      g_a[0] = 77; g_a[1] = 77; g_a[2] = 77; g_d[1] = 32'h5555_AAAA;
      run_group("R5 old-value", 0);
      g_en = '0; g_we = '0; g_en[3] = 1; g_a[3] = 77;
      run_group("R5 R6 readback", 0);
      // R9: two enabled reads, disabled lanes carry writes to address 0
      g_en = '0; g_we = '1; g_we[2] = 0; g_we[9] = 0;
      for (int l = 0; l < LANES; l++) begin g_a[l] = 0; g_d[l] = 32'hBAD0_0000; end
      g_en[2] = 1; g_en[9] = 1; g_a[2] = 0; g_a[9] = 16;
      run_group("R9 sparse", 0);
      g_en = '1; g_we = '0;
      for (int l = 0; l < LANES; l++) g_a[l] = AW'(l);
      run_group("R9 R7 untouched", 0);
      // R10: empty group
      g_en = '0; g_we = '0;
      run_group("R10 empty", 0);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule